// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor link and steps through the bus and handshake cycles of one coprocessor instruction at a time. A one-cycle `start` pulse in idle latches the instruction class, the condition outcome and the computed transfer base address. While it offers the instruction, the block holds the coprocessor-instruction strobe low and the address at pc+8, and it samples the coprocessor's two active-low response lines on every clock. The response selects one of four outcomes: proceed, keep waiting, trap because no coprocessor answered, or abandon for a pending interrupt.

Once the coprocessor accepts, the block runs one of two kinds of transfer. A memory burst steps through sequential addresses from the base address until the coprocessor marks the last word. A single-word register move takes place at pc+12. A move into a core register adds one internal write-back cycle. When no coprocessor answers, the block releases the strobe, raises a trap request and fetches from the trap vector and vector+4. The block reports the end of every instruction with `done`, or with `abort` when an instruction is abandoned.

Top module: `cphs_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. From the next cycle, `cp_instr_n` is 1, `mem_req` is 0 and `busy` is 0.
- R2: In every offer cycle (the cycle after an accepted `start` with `cond_pass`=1, and each busy-wait repeat), `cp_instr_n` is 0, `op_fetch` is 1 and `addr` is pc+8. When `cp_accept_n`=0 and `cp_wait_n`=1, the offer repeats in the next cycle with the same address.
- R3: If `cp_accept_n`=1 and `cp_wait_n`=1 are sampled during an offer, the next cycle has `cp_instr_n`=1, `trap_req`=1, `mem_req`=1, `seq`=0 and `addr`=TRAP_VEC. The cycle after that has `mem_req`=1, `seq`=1, `addr`=TRAP_VEC+4 and `done`=1.
- R4: A burst (op 0 or 1) starts after an offer that samples both lines low. Its first word uses the base address, and each later word adds 4 modulo 2^AW. In burst cycles `cp_instr_n`=1, `op_fetch`=0, `mem_req`=1 and `seq`=1, except on the word where both lines are sampled high: that word has `seq`=0 and `done`=1.
- R5: `wr` is 1 during every burst word of op 1 (coprocessor to memory) and 0 during every burst word of op 0 (memory to coprocessor).
- R6: In the offer cycle that samples both lines low, `mem_req` is 1 for ops 0 and 1 and 0 for ops 2 and 3. In all other offer cycles it is 0.
- R7: Op 2 (coprocessor to core register) makes one cycle at pc+12 with `wr`=0, then one cycle at pc+12 with `reg_wr`=1 and `done`=1.
- R8: Op 3 (core register to coprocessor) makes one cycle at pc+12 with `wr`=1, `reg_drive`=1 and `done`=1, and then returns to idle with no write-back cycle.
- R9: A `start` with `cond_pass`=0 gives exactly one cycle with `cp_instr_n`=1, `op_fetch`=1, `mem_req`=1, `seq`=1, `addr`=pc+8 and `done`=1, and then idle.
- R10: When `irq_pend`=1 in a busy-wait offer cycle, `abort` is 1 in that cycle and the block is idle from the next cycle. `irq_pend` has no effect in an offer that samples both lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an instruction (sampled in idle only) |
| op | input | 2 | 0 mem->cp burst, 1 cp->mem burst, 2 cp->reg move, 3 reg->cp move |
| cond_pass | input | 1 | Condition code of the instruction is met |
| irq_pend | input | 1 | Interrupt pending; may abandon a busy-wait |
| pc | input | AW | Address of the instruction |
| base_addr | input | AW | Computed first burst address |
| cp_accept_n | input | 1 | Coprocessor acknowledge, active low |
| cp_wait_n | input | 1 | Coprocessor busy/last line, active low |
| cp_instr_n | output | 1 | Coprocessor-instruction strobe, active low |
| op_fetch | output | 1 | Current access is an opcode fetch |
| mem_req | output | 1 | Memory request |
| seq | output | 1 | Next access is sequential |
| wr | output | 1 | 1 write, 0 read |
| addr | output | AW | Bus address |
| reg_drive | output | 1 | Register value is driven onto the data bus |
| reg_wr | output | 1 | Destination register write-back cycle |
| trap_req | output | 1 | Undefined-instruction trap request |
| abort | output | 1 | Instruction abandoned in this cycle |
| done | output | 1 | Last cycle of the instruction |
| busy | output | 1 | Not idle |

## Verification
The bench builds the block with AW=16 and TRAP_VEC=16'h0004, so addresses print as short values. One burst starts at 16'hFFF8, which makes the 4-byte step wrap through zero within three words. The narrow vector keeps the trap fetch pair at 0004 and 0008, clear of the pc+8 and pc+12 offsets at 0108 and 010C, so an address taken from the wrong source shows up in the compared value.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

    typedef enum logic [1:0] {
        OP_MEM_TO_CP = 2'd0,
        OP_CP_TO_MEM = 2'd1,
        OP_CP_TO_REG = 2'd2,
        OP_REG_TO_CP = 2'd3
    } cp_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SKIP,
        S_OFFER,
        S_BURST,
        S_MOVE,
        S_WBACK,
        S_TRAP0,
        S_TRAP1
    } seq_state_e;

    typedef enum logic [2:0] {
        A_FETCH,
        A_NEXT,
        A_BURST,
        A_VEC,
        A_VEC_NEXT
    } addr_sel_e;

    typedef enum logic [1:0] {
        RSP_GO,
        RSP_WAIT,
        RSP_NONE
    } cp_rsp_e;

endpackage

// File: rtl/cphs_resp.sv
module cphs_resp
    import cphs_pkg::*;
(
    input  logic    accept_n,
    input  logic    wait_n,
    output cp_rsp_e rsp
);
    always_comb begin
        if (accept_n && wait_n)
            rsp = RSP_NONE;
        else if (!accept_n && !wait_n)
            rsp = RSP_GO;
        else
            rsp = RSP_WAIT;
    end
endmodule

// File: rtl/cphs_addr.sv
module cphs_addr
    import cphs_pkg::*;
#(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   TRAP_VEC = 'h4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    input  addr_sel_e     sel,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] WORD_STEP  = AW'(4);
    localparam logic [AW-1:0] OFS_FETCH  = AW'(8);
    localparam logic [AW-1:0] OFS_NEXT   = AW'(12);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)
            ptr_d = base;
        else if (step)
            ptr_d = ptr_q + WORD_STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    always_comb begin
        case (sel)
            A_NEXT:     addr = pc + OFS_NEXT;
            A_BURST:    addr = ptr_q;
            A_VEC:      addr = TRAP_VEC;
            A_VEC_NEXT: addr = TRAP_VEC + WORD_STEP;
            default:    addr = pc + OFS_FETCH;
        endcase
    end
endmodule

// File: rtl/cphs_ctrl.sv
module cphs_ctrl
    import cphs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  cp_op_e    op,
    input  logic      cond_pass,
    input  logic      irq_pend,
    input  cp_rsp_e   rsp,
    output addr_sel_e asel,
    output logic      addr_load,
    output logic      addr_step,
    output logic      cp_instr_n,
    output logic      op_fetch,
    output logic      mem_req,
    output logic      seq,
    output logic      wr,
    output logic      reg_drive,
    output logic      reg_wr,
    output logic      trap_req,
    output logic      abort,
    output logic      done,
    output logic      busy
);
    typedef struct packed {
        seq_state_e st;
        cp_op_e     op;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic is_burst;

    assign is_burst = (ctl_q.op == OP_MEM_TO_CP) || (ctl_q.op == OP_CP_TO_MEM);

    always_comb begin
        ctl_d      = ctl_q;
        asel       = A_FETCH;
        addr_load  = 1'b0;
        addr_step  = 1'b0;
        cp_instr_n = 1'b1;
        op_fetch   = 1'b0;
        mem_req    = 1'b0;
        seq        = 1'b0;
        wr         = 1'b0;
        reg_drive  = 1'b0;
        reg_wr     = 1'b0;
        trap_req   = 1'b0;
        abort      = 1'b0;
        done       = 1'b0;

        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.op  = op;
                    addr_load = 1'b1;
                    ctl_d.st  = cond_pass ? S_OFFER : S_SKIP;
                end
            end
            S_SKIP: begin
                op_fetch = 1'b1;
                mem_req  = 1'b1;
                seq      = 1'b1;
                done     = 1'b1;
                ctl_d.st = S_IDLE;
            end
            S_OFFER: begin
                cp_instr_n = 1'b0;
                op_fetch   = 1'b1;
                case (rsp)
                    RSP_GO: begin
                        mem_req  = is_burst;
                        ctl_d.st = is_burst ? S_BURST : S_MOVE;
                    end
                    RSP_NONE: ctl_d.st = S_TRAP0;
                    default: begin
                        if (irq_pend) begin
                            abort    = 1'b1;
                            ctl_d.st = S_IDLE;
                        end
                    end
                endcase
            end
            S_BURST: begin
                asel      = A_BURST;
                mem_req   = 1'b1;
                addr_step = 1'b1;
                wr        = (ctl_q.op == OP_CP_TO_MEM);
                if (rsp == RSP_NONE) begin
                    done     = 1'b1;
                    ctl_d.st = S_IDLE;
                end else begin
                    seq = 1'b1;
                end
            end
            S_MOVE: begin
                asel = A_NEXT;
                if (ctl_q.op == OP_REG_TO_CP) begin
                    wr        = 1'b1;
                    reg_drive = 1'b1;
                    done      = 1'b1;
                    ctl_d.st  = S_IDLE;
                end else begin
                    ctl_d.st = S_WBACK;
                end
            end
            S_WBACK: begin
                asel     = A_NEXT;
                reg_wr   = 1'b1;
                done     = 1'b1;
                ctl_d.st = S_IDLE;
            end
            S_TRAP0: begin
                asel     = A_VEC;
                trap_req = 1'b1;
                mem_req  = 1'b1;
                op_fetch = 1'b1;
                ctl_d.st = S_TRAP1;
            end
            S_TRAP1: begin
                asel     = A_VEC_NEXT;
                mem_req  = 1'b1;
                seq      = 1'b1;
                op_fetch = 1'b1;
                done     = 1'b1;
                ctl_d.st = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    assign busy = (ctl_q.st != S_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st <= S_IDLE;
            ctl_q.op <= OP_MEM_TO_CP;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/cphs_seq.sv
module cphs_seq
    import cphs_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] TRAP_VEC = 'h4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          cond_pass,
    input  logic          irq_pend,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] base_addr,
    input  logic          cp_accept_n,
    input  logic          cp_wait_n,
    output logic          cp_instr_n,
    output logic          op_fetch,
    output logic          mem_req,
    output logic          seq,
    output logic          wr,
    output logic [AW-1:0] addr,
    output logic          reg_drive,
    output logic          reg_wr,
    output logic          trap_req,
    output logic          abort,
    output logic          done,
    output logic          busy
);
    cp_rsp_e   rsp;
    addr_sel_e asel;
    logic      addr_load;
    logic      addr_step;

    cphs_resp u_resp (
        .accept_n (cp_accept_n),
        .wait_n   (cp_wait_n),
        .rsp      (rsp)
    );

    cphs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (cp_op_e'(op)),
        .cond_pass  (cond_pass),
        .irq_pend   (irq_pend),
        .rsp        (rsp),
        .asel       (asel),
        .addr_load  (addr_load),
        .addr_step  (addr_step),
        .cp_instr_n (cp_instr_n),
        .op_fetch   (op_fetch),
        .mem_req    (mem_req),
        .seq        (seq),
        .wr         (wr),
        .reg_drive  (reg_drive),
        .reg_wr     (reg_wr),
        .trap_req   (trap_req),
        .abort      (abort),
        .done       (done),
        .busy       (busy)
    );

    cphs_addr #(
        .AW       (AW),
        .TRAP_VEC (TRAP_VEC)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (addr_load),
        .step  (addr_step),
        .base  (base_addr),
        .pc    (pc),
        .sel   (asel),
        .addr  (addr)
    );
endmodule

// File: rtl/cphs_seq_chk.sv
module cphs_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          cond_pass,
    input logic          irq_pend,
    input logic          cp_accept_n,
    input logic          cp_wait_n,
    input logic          cp_instr_n,
    input logic          op_fetch,
    input logic          mem_req,
    input logic          seq,
    input logic [AW-1:0] addr,
    input logic          trap_req,
    input logic          abort,
    input logic          done,
    input logic          busy
);
    localparam logic [AW-1:0] STEP = AW'(4);

    AST_WAIT_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_instr_n && !cp_accept_n && cp_wait_n && !irq_pend)
        |=> (!cp_instr_n && addr == $past(addr)));  // R2

    AST_ABSENT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_instr_n && cp_accept_n && cp_wait_n) |=> (trap_req && cp_instr_n));  // R3

    AST_TRAP_IS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (op_fetch && mem_req && !seq));  // R3

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !op_fetch && cp_instr_n && seq)
        |=> (mem_req && !op_fetch && addr == $past(addr) + STEP));  // R4

    AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cond_pass) |=> (done && cp_instr_n && mem_req));  // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && cp_instr_n && !mem_req));  // R10
endmodule

bind cphs_seq cphs_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cond_pass   (cond_pass),
    .irq_pend    (irq_pend),
    .cp_accept_n (cp_accept_n),
    .cp_wait_n   (cp_wait_n),
    .cp_instr_n  (cp_instr_n),
    .op_fetch    (op_fetch),
    .mem_req     (mem_req),
    .seq         (seq),
    .addr        (addr),
    .trap_req    (trap_req),
    .abort       (abort),
    .done        (done),
    .busy        (busy)
);

// File: tb/cphs_seq_tb.sv
`timescale 1ns/1ps
module cphs_seq_tb;
    localparam int            AW  = 16;
    localparam logic [AW-1:0] VEC = 16'h0004;
    localparam logic [AW-1:0] PC  = 16'h0100;
    localparam logic [AW-1:0] P8  = PC + 16'd8;
    localparam logic [AW-1:0] P12 = PC + 16'd12;

    typedef struct packed {
        logic instr_n, fetch, req, sq, w, drv, rwr, trap, abt, dn, bsy;
        logic [AW-1:0] a;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = 2'd0;
    logic cond_pass = 1'b1;
    logic irq_pend = 1'b0;
    logic [AW-1:0] pc = PC;
    logic [AW-1:0] base_addr = '0;
    logic cp_accept_n = 1'b1;
    logic cp_wait_n = 1'b1;
    logic cp_instr_n, op_fetch, mem_req, seq, wr, reg_drive, reg_wr;
    logic trap_req, abort, done, busy;
    logic [AW-1:0] addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    cphs_seq #(.AW(AW), .TRAP_VEC(VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond_pass(cond_pass),
        .irq_pend(irq_pend), .pc(pc), .base_addr(base_addr),
        .cp_accept_n(cp_accept_n), .cp_wait_n(cp_wait_n),
        .cp_instr_n(cp_instr_n), .op_fetch(op_fetch), .mem_req(mem_req), .seq(seq),
        .wr(wr), .addr(addr), .reg_drive(reg_drive), .reg_wr(reg_wr),
        .trap_req(trap_req), .abort(abort), .done(done), .busy(busy)
    );

    function automatic exp_t mk(logic i, logic f, logic r, logic s, logic w, logic [AW-1:0] a,
                                logic d, logic rw, logic t, logic ab, logic dn, logic b);
        exp_t e;
        e = '{instr_n:i, fetch:f, req:r, sq:s, w:w, drv:d, rwr:rw, trap:t, abt:ab, dn:dn, bsy:b, a:a};
        return e;
    endfunction

    function automatic exp_t e_idle();           return mk(1,0,0,0,0,P8,0,0,0,0,0,0); endfunction
    function automatic exp_t e_offer(logic r);   return mk(0,1,r,0,0,P8,0,0,0,0,0,1); endfunction
    function automatic exp_t e_burst(logic [AW-1:0] a, logic last, logic w);
        return mk(1,0,1,!last,w,a,0,0,0,0,last,1);
    endfunction

    function automatic exp_t actual();
        return mk(cp_instr_n, op_fetch, mem_req, seq, wr, addr, reg_drive, reg_wr,
                  trap_req, abort, done, busy);
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t e, got;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = actual();
                checks++;
                if (got !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, got, e);
                end
            end
        end
    end

    task automatic issue(input logic [1:0] o, input logic c, input logic [AW-1:0] b, input string t);
        @(posedge clk); #1;
        start = 1'b1; op = o; cond_pass = c; base_addr = b;
        cp_accept_n = 1'b1; cp_wait_n = 1'b1; irq_pend = 1'b0;
        exp_q.push_back(e_idle()); tag_q.push_back(t);
    endtask

    task automatic step(input logic an, input logic wn, input logic irq, input exp_t e, input string t);
        @(posedge clk); #1;
        start = 1'b0; cp_accept_n = an; cp_wait_n = wn; irq_pend = irq;
        exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic direct(input logic ok, input string t);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected idle (instr_n=1 req=0 busy=0)", t, actual());
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        direct(cp_instr_n === 1'b1 && mem_req === 1'b0 && busy === 1'b0, "R1 reset");
        @(posedge clk); #1 rst_n = 1'b1;

        // R9 condition fails: single fetch cycle
        issue(2'd0, 1'b0, 16'h3000, "R9 start");
        step(1,1,0, mk(1,1,1,1,0,P8,0,0,0,0,1,1), "R9 skip cycle");
        step(1,1,0, e_idle(), "R9 back to idle");

        // R4 R5 R6 mem->cp burst of three words
        issue(2'd0, 1'b1, 16'h2000, "R4 start");
        step(0,0,0, e_offer(1), "R2 R6 offer accepted burst");
        step(0,0,0, e_burst(16'h2000,0,0), "R4 R5 word0");
        step(0,0,0, e_burst(16'h2004,0,0), "R4 word1");
        step(1,1,0, e_burst(16'h2008,1,0), "R4 last word");
        step(1,1,0, e_idle(), "R4 idle after");

        // R4 R5 cp->mem burst with two waits and address wrap
        issue(2'd1, 1'b1, 16'hFFF8, "R5 start");
        step(0,1,0, e_offer(0), "R2 R6 wait1");
        step(0,1,0, e_offer(0), "R2 wait2");
        step(0,0,0, e_offer(1), "R6 go");
        step(0,0,0, e_burst(16'hFFF8,0,1), "R5 write word0");
        step(0,0,0, e_burst(16'hFFFC,0,1), "R5 write word1");
        step(1,1,0, e_burst(16'h0000,1,1), "R4 wrap last");
        step(1,1,0, e_idle(), "R5 idle after");

        // R7 cp->reg with one wait
        issue(2'd2, 1'b1, 16'h0, "R7 start");
        step(0,1,0, e_offer(0), "R7 wait");
        step(0,0,0, e_offer(0), "R6 R7 go no req");
        step(1,1,0, mk(1,0,0,0,0,P12,0,0,0,0,0,1), "R7 move");
        step(1,1,0, mk(1,0,0,0,0,P12,0,1,0,0,1,1), "R7 writeback");
        step(1,1,0, e_idle(), "R7 idle");

        // R8 reg->cp
        issue(2'd3, 1'b1, 16'h0, "R8 start");
        step(0,0,0, e_offer(0), "R6 R8 go");
        step(1,1,0, mk(1,0,0,0,1,P12,1,0,0,0,1,1), "R8 move");
        step(1,1,0, e_idle(), "R8 no writeback");

        // R3 absent coprocessor
        issue(2'd0, 1'b1, 16'h5000, "R3 start");
        step(1,1,0, e_offer(0), "R3 offer unanswered");
        step(1,1,0, mk(1,1,1,0,0,VEC,0,0,1,0,0,1), "R3 vector");
        step(1,1,0, mk(1,1,1,1,0,VEC+16'd4,0,0,0,0,1,1), "R3 vector+4");
        step(1,1,0, e_idle(), "R3 idle");

        // R10 abandon during busy-wait
        issue(2'd1, 1'b1, 16'h6000, "R10 start");
        step(0,1,0, e_offer(0), "R10 wait");
        step(0,1,1, mk(0,1,0,0,0,P8,0,0,0,1,0,1), "R10 abort");
        step(1,1,1, e_idle(), "R10 idle after abort");

        // R10 interrupt ignored on accepting offer
        issue(2'd0, 1'b1, 16'h7000, "R10b start");
        step(0,0,1, e_offer(1), "R10 irq ignored on go");
        step(1,1,1, e_burst(16'h7000,1,0), "R10 burst proceeds");
        step(1,1,0, e_idle(), "R10b idle");

        // R1 reset in the middle of an offer
        issue(2'd2, 1'b1, 16'h0, "R1 start");
        step(0,1,0, e_offer(0), "R1 offer before reset");
        drain();
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        direct(cp_instr_n === 1'b1 && mem_req === 1'b0 && busy === 1'b0, "R1 mid-offer reset");

        repeat (2) @(posedge clk);
        drain();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule